// File: doc/BRIEF.md
# UART Line Configuration Guard

This block is the configuration register file of a 16550-style UART, reduced to the part that has to cope with a busy serial engine. It sits on a byte-wide register bus and drives the active line-control byte and the 16-bit baud divisor into the transmitter and receiver. It reads back the engine's busy flag and the two FIFO fill levels. Software reaches the divisor bytes through the divisor-latch access bit of the line-control byte. A small FIFO control register supplies the FIFO enable, the receive trigger selection and one-cycle reset pulses.

The engine must never see its framing or baud rate change in the middle of a character. A line-control or divisor write that arrives while the engine is busy is therefore not applied directly. With the change-enable bit of the halt register clear, the write is discarded and a busy interrupt is raised. Software clears that interrupt by reading the status register. With change-enable set, the write lands in a staged copy instead. Setting the commit bit then moves the staged copy into the active registers at the first cycle the engine is idle, and the bit clears itself. When the engine is idle, writes apply at once.

Top module: `uart_cfg_guard`

## Requirements
- R1: Reading word index 2 returns 0x7 in bits 3:0 while a busy interrupt is pending and enabled, and 0x1 otherwise. Bits 7:6 both equal the FIFO enable, and bits 5:4 read 0.
- R2: While `busy_i` is high and halt bit 1 is clear, a write to the line-control byte (index 3) or to an accessible divisor byte is discarded. The active outputs keep their values, and the busy interrupt becomes pending on the next cycle.
- R3: Bit 0 of word index 31 reads `busy_i`, and its other bits read 0. A read of index 31 clears a pending busy interrupt.
- R4: While `busy_i` is high and halt bit 1 (0x02) is set, line-control and divisor writes go into a staged copy. No interrupt is raised and the active outputs do not change. Reads of indices 3, 0 and 1 return the staged values.
- R5: Writing halt (index 41) with bit 2 (0x04) set requests a commit, which reads back as bit 2. At the first clock edge where `busy_i` is low, the staged line-control byte and divisor are copied to the active outputs and bit 2 returns to 0. Halt bit 1 reads back as written, and the other halt bits read 0.
- R6: Divisor low (index 0) and divisor high (index 1) are accessible only while bit 7 of the line-control byte is set. Otherwise writes to those indices are ignored and reads return 0.
- R7: Index 32 reads `tx_level_i` and index 33 reads `rx_level_i`, both zero-extended. Writes to these indices have no effect.
- R8: A write to index 2 sets the FIFO enable from bit 0 and the receive trigger select from bits 7:6. Bit 1 pulses `rx_fifo_rst_o` and bit 2 pulses `tx_fifo_rst_o`, each high for exactly the cycle after the write. Neither reset bit reads back.
- R9: While `busy_i` is low, line-control and divisor writes appear on the active outputs on the cycle after the write, whatever the halt register holds.
- R10: `irq_o` is high exactly when a busy interrupt is pending and `irq_en_i` is high. Lowering `irq_en_i` masks the output but keeps the pending state.
- R11: Reset gives a line-control byte of 0x03, a divisor of 1, a halt register of 0, FIFOs disabled and no pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Register word index |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe; qualifies read side effects |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| busy_i | input | 1 | Serial engine is shifting a character |
| irq_en_i | input | 1 | Enables the busy interrupt onto `irq_o` |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| lcr_o | output | 8 | Active line-control byte |
| divisor_o | output | 16 | Active baud divisor |
| fifo_en_o | output | 1 | FIFO enable |
| rx_trig_o | output | 2 | Receive trigger select |
| rx_fifo_rst_o | output | 1 | One-cycle receive FIFO reset pulse |
| tx_fifo_rst_o | output | 1 | One-cycle transmit FIFO reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench stages a complete new line-control byte and divisor while the engine is busy, then drops busy. A design that applied staged writes at once, or that left the commit bit set, would show the new framing too early or fail to report the completed commit. It also writes while busy with change-enable clear, where a design that let the write through or forgot the interrupt would change the outputs or show the wrong identification code. Other cases are the status-read clearing of the interrupt, masking by the enable input without losing the pending state, divisor access with the latch-access bit clear, and FIFO reset bits that must pulse once and never read back.

// File: rtl/ucg_pkg.sv
// Shared constants of the UART configuration guard: register word
// indices, halt register bit positions and reset values.
package ucg_pkg;
    localparam int IDX_DIV_LO = 0;
    localparam int IDX_DIV_HI = 1;
    localparam int IDX_FIFO   = 2;   // read: interrupt id, write: FIFO control
    localparam int IDX_LINE   = 3;
    localparam int IDX_STATUS = 31;
    localparam int IDX_TXLVL  = 32;
    localparam int IDX_RXLVL  = 33;
    localparam int IDX_HALT   = 41;

    localparam int HALT_CHG_BIT    = 1;
    localparam int HALT_COMMIT_BIT = 2;

    localparam logic [3:0] ID_BUSY = 4'h7;
    localparam logic [3:0] ID_NONE = 4'h1;

    localparam logic [7:0]  LINE_RESET = 8'h03;
    localparam logic [15:0] DIV_RESET  = 16'h0001;
endpackage

// File: rtl/ucg_cfg_regs.sv
// Active and staged copies of the line-control byte and baud divisor,
// plus the halt register (change-enable and self-clearing commit).
// Assumes the caller has already qualified divisor writes with the
// latch-access bit. The active copy only ever changes on an edge where
// busy_i is low.
module ucg_cfg_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy_i,
    input  logic        wr_line_i,
    input  logic        wr_dlo_i,
    input  logic        wr_dhi_i,
    input  logic        wr_halt_i,
    input  logic [7:0]  wdata_i,
    input  logic        halt_chg_i,
    input  logic        halt_commit_i,
    output logic [7:0]  line_act_o,
    output logic [15:0] div_act_o,
    output logic [7:0]  line_stg_o,
    output logic [15:0] div_stg_o,
    output logic        chg_en_o,
    output logic        commit_pend_o,
    output logic        drop_o
);
    logic any_wr;
    logic accept;

    assign any_wr = wr_line_i | wr_dlo_i | wr_dhi_i;
    assign accept = !busy_i || chg_en_o;
    assign drop_o = any_wr && !accept;

    // Staged copy: follows every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_stg_o <= ucg_pkg::LINE_RESET;
            div_stg_o  <= ucg_pkg::DIV_RESET;
        end else if (accept) begin
            if (wr_line_i) line_stg_o      <= wdata_i;
            if (wr_dlo_i)  div_stg_o[7:0]  <= wdata_i;
            if (wr_dhi_i)  div_stg_o[15:8] <= wdata_i;
        end
    end

    // Active copy: commit then direct writes, only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_act_o <= ucg_pkg::LINE_RESET;
            div_act_o  <= ucg_pkg::DIV_RESET;
        end else if (!busy_i) begin
            if (commit_pend_o) begin
                line_act_o <= line_stg_o;
                div_act_o  <= div_stg_o;
            end
            if (wr_line_i) line_act_o      <= wdata_i;
            if (wr_dlo_i)  div_act_o[7:0]  <= wdata_i;
            if (wr_dhi_i)  div_act_o[15:8] <= wdata_i;
        end
    end

    // Halt register: change-enable is plain storage, commit clears itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_en_o      <= 1'b0;
            commit_pend_o <= 1'b0;
        end else begin
            if (wr_halt_i) chg_en_o <= halt_chg_i;
            commit_pend_o <= (commit_pend_o && busy_i) || (wr_halt_i && halt_commit_i);
        end
    end

    // R2 / R4 / R5: nothing reaches the engine while it is busy.
    p_hold_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(line_act_o) && $stable(div_act_o)));

    // R9: an idle write to the line byte shows on the next cycle.
    p_idle_apply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_line_i && !busy_i) |=> (line_act_o == $past(wdata_i)));

    // R5: a pending commit is gone after the first idle edge.
    p_commit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pend_o && !busy_i && !(wr_halt_i && halt_commit_i)) |=> !commit_pend_o);

    // R5: a commit copies the staged line byte into the active one.
    p_commit_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pend_o && !busy_i && !any_wr) |=> (line_act_o == $past(line_stg_o)));
endmodule

// File: rtl/ucg_busy_irq.sv
// Busy-write interrupt source: latched on a discarded write, cleared by
// a status read, masked onto the request line by the enable input.
// A new discard in the same cycle as a clearing read wins.
module ucg_busy_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic pend_o,
    output logic irq_o
);
    // Pending flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= set_i || (pend_o && !clr_i);
    end

    assign irq_o = pend_o && en_i;

    // R2: a discarded write always leaves the interrupt pending.
    p_drop_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R3: a status read with no new discard clears it.
    p_status_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/ucg_fifo_ctl.sv
// FIFO control: holds enable and trigger select, and turns the reset bits
// of a write into one-cycle pulses that are never stored.
module ucg_fifo_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       en_bit_i,
    input  logic       rx_rst_bit_i,
    input  logic       tx_rst_bit_i,
    input  logic [1:0] trig_i,
    output logic       fifo_en_o,
    output logic [1:0] rx_trig_o,
    output logic       rx_rst_o,
    output logic       tx_rst_o
);
    // Stored fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_o <= 1'b0;
            rx_trig_o <= 2'b00;
        end else if (wr_i) begin
            fifo_en_o <= en_bit_i;
            rx_trig_o <= trig_i;
        end
    end

    // Reset pulses: high only for the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rst_o <= 1'b0;
            tx_rst_o <= 1'b0;
        end else begin
            rx_rst_o <= wr_i && rx_rst_bit_i;
            tx_rst_o <= wr_i && tx_rst_bit_i;
        end
    end

    // R8: a reset pulse without a new request lasts one cycle.
    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst_o && !wr_i) |=> !rx_rst_o);
endmodule

// File: rtl/uart_cfg_guard.sv
// Top of the UART configuration guard: decodes the byte register bus,
// gates divisor access with the latch-access bit of the staged line byte,
// and assembles read data. Read data is combinational on addr_i; side
// effects of reads take place on the edge where rd_en_i is high.
// Assumes LVL_W <= 8 and ADDR_W wide enough for index 41.
module uart_cfg_guard #(
    parameter int ADDR_W = 6,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    input  logic              busy_i,
    input  logic              irq_en_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    output logic [7:0]        lcr_o,
    output logic [15:0]       divisor_o,
    output logic              fifo_en_o,
    output logic [1:0]        rx_trig_o,
    output logic              rx_fifo_rst_o,
    output logic              tx_fifo_rst_o,
    output logic              irq_o
);
    import ucg_pkg::*;

    localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(IDX_DIV_LO);
    localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(IDX_DIV_HI);
    localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(IDX_FIFO);
    localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(IDX_LINE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STATUS);
    localparam logic [ADDR_W-1:0] A_TXL  = ADDR_W'(IDX_TXLVL);
    localparam logic [ADDR_W-1:0] A_RXL  = ADDR_W'(IDX_RXLVL);
    localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(IDX_HALT);

    logic [7:0]  line_stg;
    logic [15:0] div_stg;
    logic        chg_en, commit_pend, drop, pend;
    logic        dlab;
    logic        wr_line, wr_dlo, wr_dhi, wr_halt, wr_fifo, rd_status;

    assign dlab      = line_stg[7];
    assign wr_line   = wr_en_i && (addr_i == A_LINE);
    assign wr_dlo    = wr_en_i && dlab && (addr_i == A_DLO);
    assign wr_dhi    = wr_en_i && dlab && (addr_i == A_DHI);
    assign wr_halt   = wr_en_i && (addr_i == A_HALT);
    assign wr_fifo   = wr_en_i && (addr_i == A_FIFO);
    assign rd_status = rd_en_i && (addr_i == A_STAT);

    ucg_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .wr_line_i    (wr_line),
        .wr_dlo_i     (wr_dlo),
        .wr_dhi_i     (wr_dhi),
        .wr_halt_i    (wr_halt),
        .wdata_i      (wdata_i),
        .halt_chg_i   (wdata_i[HALT_CHG_BIT]),
        .halt_commit_i(wdata_i[HALT_COMMIT_BIT]),
        .line_act_o   (lcr_o),
        .div_act_o    (divisor_o),
        .line_stg_o   (line_stg),
        .div_stg_o    (div_stg),
        .chg_en_o     (chg_en),
        .commit_pend_o(commit_pend),
        .drop_o       (drop)
    );

    ucg_busy_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (drop),
        .clr_i (rd_status),
        .en_i  (irq_en_i),
        .pend_o(pend),
        .irq_o (irq_o)
    );

    ucg_fifo_ctl u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_fifo),
        .en_bit_i    (wdata_i[0]),
        .rx_rst_bit_i(wdata_i[1]),
        .tx_rst_bit_i(wdata_i[2]),
        .trig_i      (wdata_i[7:6]),
        .fifo_en_o   (fifo_en_o),
        .rx_trig_o   (rx_trig_o),
        .rx_rst_o    (rx_fifo_rst_o),
        .tx_rst_o    (tx_fifo_rst_o)
    );

    // Read data multiplexer.
    always_comb begin
        rdata_o = 8'h00;
        case (addr_i)
            A_DLO:  rdata_o = dlab ? div_stg[7:0]  : 8'h00;
            A_DHI:  rdata_o = dlab ? div_stg[15:8] : 8'h00;
            A_FIFO: rdata_o = {fifo_en_o, fifo_en_o, 2'b00, (pend && irq_en_i) ? ID_BUSY : ID_NONE};
            A_LINE: rdata_o = line_stg;
            A_STAT: rdata_o = {7'b0, busy_i};
            A_TXL:  rdata_o = 8'(tx_level_i);
            A_RXL:  rdata_o = 8'(rx_level_i);
            A_HALT: rdata_o = {5'b0, commit_pend, chg_en, 1'b0};
            default: rdata_o = 8'h00;
        endcase
    end

    // R4: a staged write while busy never raises the interrupt.
    p_staged_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && chg_en && (wr_line || wr_dlo || wr_dhi) && !pend) |=> !pend);

    // R10: the request line never shows a masked or absent interrupt.
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i && (rdata_o[3:0] == ID_BUSY || addr_i != A_FIFO)));
endmodule

// File: tb/uart_cfg_guard_test.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor at the
// falling edge pops and compares them against rdata_o.
module uart_cfg_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int LVL_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        rdata;
    logic              busy = 1'b0;
    logic              irq_en = 1'b0;
    logic [LVL_W-1:0]  tx_lvl = '0;
    logic [LVL_W-1:0]  rx_lvl = '0;
    logic [7:0]        lcr;
    logic [15:0]       divisor;
    logic              fifo_en, rx_rst, tx_rst, irq;
    logic [1:0]        rx_trig;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_cfg_guard #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .busy_i(busy), .irq_en_i(irq_en), .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
        .lcr_o(lcr), .divisor_o(divisor), .fifo_en_o(fifo_en), .rx_trig_o(rx_trig),
        .rx_fifo_rst_o(rx_rst), .tx_fifo_rst_o(tx_rst), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // Monitor: compare read data with the oldest queued expectation.
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: read with no expectation, actual 0x%0h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({24'b0, rdata}, {24'b0, e}, t);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11: reset state
        chk(lcr, 8'h03, "R11 line byte after reset");
        chk(divisor, 16'h0001, "R11 divisor after reset");
        chk(irq, 0, "R11 no interrupt after reset");
        chk(fifo_en, 0, "R11 FIFO disabled after reset");
        bus_rd(41, 8'h00, "R11 halt after reset");
        bus_rd(2, 8'h01, "R11/R1 id none after reset");

        // R9: idle writes apply at once, whatever halt holds
        bus_wr(3, 8'h1B);
        chk(lcr, 8'h1B, "R9 idle line write");
        bus_wr(41, 8'h02);
        bus_wr(3, 8'h07);
        chk(lcr, 8'h07, "R9 idle write with change-enable set");
        bus_wr(41, 8'h00);
        bus_wr(3, 8'h03);

        // R6: divisor gated by latch-access bit
        bus_wr(0, 8'h55);
        chk(divisor, 16'h0001, "R6 divisor write ignored without access bit");
        bus_rd(0, 8'h00, "R6 divisor low reads 0 without access bit");
        bus_wr(3, 8'h83);
        bus_wr(0, 8'h34);
        bus_wr(1, 8'h12);
        chk(divisor, 16'h1234, "R6/R9 divisor written with access bit");
        bus_rd(0, 8'h34, "R6 divisor low readback");
        bus_rd(1, 8'h12, "R6 divisor high readback");
        bus_wr(3, 8'h03);

        // R2: busy write discarded and interrupt raised
        irq_en = 1'b1;
        busy = 1'b1;
        bus_wr(3, 8'h1F);
        chk(lcr, 8'h03, "R2 busy write discarded");
        chk(irq, 1, "R2 busy interrupt raised");
        bus_rd(3, 8'h03, "R2 line readback unchanged");
        bus_rd(2, 8'h07, "R1 id busy");
        // R10: masking keeps pending state
        irq_en = 1'b0; #1;
        chk(irq, 0, "R10 masked interrupt");
        bus_rd(2, 8'h01, "R1/R10 id none while masked");
        irq_en = 1'b1; #1;
        chk(irq, 1, "R10 pending kept under mask");
        // R3: status read shows busy and clears pending
        bus_rd(31, 8'h01, "R3 status busy bit");
        chk(irq, 0, "R3 status read clears interrupt");
        bus_rd(2, 8'h01, "R3 id none after clear");

        // R4/R5: staging while busy, then commit on idle
        bus_wr(41, 8'h02);
        bus_wr(3, 8'h83);
        chk(irq, 0, "R4 staged write raises no interrupt");
        chk(lcr, 8'h03, "R4 active line held while staging");
        bus_rd(3, 8'h83, "R4 staged line readback");
        bus_wr(0, 8'h78);
        bus_wr(1, 8'h56);
        chk(divisor, 16'h1234, "R4 active divisor held while staging");
        bus_rd(1, 8'h56, "R4 staged divisor high readback");
        bus_wr(3, 8'h1B);
        bus_wr(41, 8'h06);
        bus_rd(41, 8'h06, "R5 commit pending while busy");
        chk(lcr, 8'h03, "R5 no apply while busy");
        busy = 1'b0;
        tick();
        chk(lcr, 8'h1B, "R5 committed line byte");
        chk(divisor, 16'h5678, "R5 committed divisor");
        bus_rd(41, 8'h02, "R5 commit bit self-cleared");
        bus_rd(31, 8'h00, "R3 status idle");
        bus_wr(41, 8'h00);

        // R7: FIFO levels, read-only
        tx_lvl = 7'd40; rx_lvl = 7'd5;
        bus_rd(32, 8'd40, "R7 transmit level");
        bus_rd(33, 8'd5, "R7 receive level");
        bus_wr(32, 8'hFF);
        bus_rd(32, 8'd40, "R7 transmit level ignores writes");

        // R8: FIFO control and reset pulses
        bus_wr(2, 8'hC7);
        chk(rx_rst, 1, "R8 receive reset pulse");
        chk(tx_rst, 1, "R8 transmit reset pulse");
        chk(fifo_en, 1, "R8 FIFO enable");
        chk(rx_trig, 2'd3, "R8 trigger select");
        tick();
        chk(rx_rst, 0, "R8 receive reset pulse ends");
        chk(tx_rst, 0, "R8 transmit reset pulse ends");
        bus_rd(2, 8'hC1, "R8/R1 reset bits do not read back");

        tick();
        finish_run();
    end
endmodule